// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block sits beside the execute stage of a five-stage in-order integer pipeline. It looks at the two source register numbers of the instruction now in execute. It compares them with the destination register numbers held in the execute/memory and memory/writeback pipeline registers. For each ALU operand it produces a 2-bit select code and drives a three-way multiplexer. The multiplexer picks the register-file value, the execute/memory result or the writeback value, so that dependent instructions run back to back without stalling.

A second path serves a load followed at once by a store of the loaded register. When that store is in the memory stage and the load is in writeback, the writeback data replaces the store's stale data at the data-memory write input. The whole unit is combinational and holds no state. The pipeline registers, the ALU, the register file and branch logic belong to the surrounding core.

Top module: `fwd_unit`

## Requirements
- R1: Select codes are 2'b00 = register-file operand, 2'b10 = execute/memory result, 2'b01 = writeback value, and 2'b11 never appears. Each operand output equals the input named by its select code.
- R2: An operand's select is 2'b10 exactly when `exm_we` is 1, `exm_rd` is nonzero and `exm_rd` equals that operand's source register.
- R3: An operand's select is 2'b01 when `wb_we` is 1, `wb_rd` is nonzero, `wb_rd` equals that operand's source register and the R2 condition does not hold for that operand.
- R4: When both the execute/memory and the writeback destinations match the same source register, the execute/memory result wins (select 2'b10).
- R5: Register 0 is never forwarded. A source of 0 always gives select 2'b00 and the register-file value, whatever the write enables are.
- R6: Operand A is decided from `ex_rs` alone and operand B from `ex_rt` alone. A match on one does not change the other.
- R7: When `mem_wr` is 1, `wb_we` and `wb_load` are 1, `wb_rd` is nonzero and `wb_rd` equals `mem_rt`, then `st_byp` is 1 and `dmem_wdata` equals `wb_value`.
- R8: Otherwise `st_byp` is 0 and `dmem_wdata` equals `mem_sdata`. A writeback that is not a load, or a memory stage that is not a store, never triggers the bypass.
- R9: All outputs depend only on the present inputs. Any input change is reflected in the same cycle, with no clock or stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs | input | 5 | Execute-stage first source register (operand A) |
| ex_rt | input | 5 | Execute-stage second source register (operand B) |
| rf_a | input | 32 | Register-file value for operand A |
| rf_b | input | 32 | Register-file value for operand B |
| exm_we | input | 1 | Execute/memory instruction writes a register |
| exm_rd | input | 5 | Execute/memory destination register |
| exm_result | input | 32 | Execute/memory ALU result |
| wb_we | input | 1 | Writeback instruction writes a register |
| wb_load | input | 1 | Writeback instruction is a load |
| wb_rd | input | 5 | Writeback destination register |
| wb_value | input | 32 | Writeback value (ALU result or load data) |
| mem_wr | input | 1 | Memory-stage instruction writes data memory |
| mem_rt | input | 5 | Store-data source register of the memory-stage store |
| mem_sdata | input | 32 | Store data carried in the execute/memory register |
| sel_a | output | 2 | Operand A select code |
| sel_b | output | 2 | Operand B select code |
| op_a | output | 32 | Forwarded operand A |
| op_b | output | 32 | Forwarded operand B |
| st_byp | output | 1 | Store-data bypass active |
| dmem_wdata | output | 32 | Data-memory write data |

## Verification
Every result of this block is due in the same cycle as its stimulus, because there is no register between any input and any output. The driver applies a vector on the falling clock edge and queues the expected selects, operands and store data at that moment. The monitor pops the entry and compares it on the following rising edge, half a period later, when all inputs have been steady. Directed vectors cover priority, register zero, operand independence and each bypass qualifier. Pseudo-random vectors over a small register range then produce frequent double matches.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_WB  = 2'b01,
        SEL_EXM = 2'b10
    } fwd_sel_e;

    localparam int NUM_OPS = 2;
endpackage

// File: rtl/fwd_select.sv
module fwd_select
    import fwd_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic             exm_we,
    input  logic [REG_W-1:0] exm_rd,
    input  logic             wb_we,
    input  logic [REG_W-1:0] wb_rd,
    output logic [1:0]       sel
);
    logic     exm_hit_d;
    logic     wb_hit_d;
    fwd_sel_e sel_d;

    always_comb begin
        exm_hit_d = exm_we && (exm_rd != '0) && (exm_rd == src);
        wb_hit_d  = wb_we  && (wb_rd  != '0) && (wb_rd  == src);
        if (exm_hit_d)
            sel_d = SEL_EXM;
        else if (wb_hit_d)
            sel_d = SEL_WB;
        else
            sel_d = SEL_RF;
    end

    assign sel = sel_d;
endmodule

// File: rtl/fwd_mux3.sv
module fwd_mux3
    import fwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] rf_val,
    input  logic [DATA_W-1:0] exm_val,
    input  logic [DATA_W-1:0] wb_val,
    output logic [DATA_W-1:0] y
);
    logic [DATA_W-1:0] y_d;

    always_comb begin
        case (sel)
            SEL_EXM: y_d = exm_val;
            SEL_WB:  y_d = wb_val;
            default: y_d = rf_val;
        endcase
    end

    assign y = y_d;
endmodule

// File: rtl/fwd_store_byp.sv
module fwd_store_byp #(
    parameter int REG_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic              mem_wr,
    input  logic [REG_W-1:0]  mem_rt,
    input  logic [DATA_W-1:0] mem_sdata,
    input  logic              wb_we,
    input  logic              wb_load,
    input  logic [REG_W-1:0]  wb_rd,
    input  logic [DATA_W-1:0] wb_value,
    output logic              byp,
    output logic [DATA_W-1:0] wdata
);
    logic              byp_d;
    logic [DATA_W-1:0] wdata_d;

    always_comb begin
        byp_d   = mem_wr && wb_we && wb_load && (wb_rd != '0) && (wb_rd == mem_rt);
        wdata_d = byp_d ? wb_value : mem_sdata;
    end

    assign byp   = byp_d;
    assign wdata = wdata_d;
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int REG_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic [REG_W-1:0]  ex_rs,
    input  logic [REG_W-1:0]  ex_rt,
    input  logic [DATA_W-1:0] rf_a,
    input  logic [DATA_W-1:0] rf_b,
    input  logic              exm_we,
    input  logic [REG_W-1:0]  exm_rd,
    input  logic [DATA_W-1:0] exm_result,
    input  logic              wb_we,
    input  logic              wb_load,
    input  logic [REG_W-1:0]  wb_rd,
    input  logic [DATA_W-1:0] wb_value,
    input  logic              mem_wr,
    input  logic [REG_W-1:0]  mem_rt,
    input  logic [DATA_W-1:0] mem_sdata,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic [DATA_W-1:0] op_a,
    output logic [DATA_W-1:0] op_b,
    output logic              st_byp,
    output logic [DATA_W-1:0] dmem_wdata
);
    logic [REG_W-1:0]  src_v [NUM_OPS];
    logic [DATA_W-1:0] rf_v  [NUM_OPS];
    logic [1:0]        sel_v [NUM_OPS];
    logic [DATA_W-1:0] op_v  [NUM_OPS];

    assign src_v[0] = ex_rs;
    assign src_v[1] = ex_rt;
    assign rf_v[0]  = rf_a;
    assign rf_v[1]  = rf_b;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        fwd_select #(.REG_W(REG_W)) u_sel (
            .src    (src_v[g]),
            .exm_we (exm_we),
            .exm_rd (exm_rd),
            .wb_we  (wb_we),
            .wb_rd  (wb_rd),
            .sel    (sel_v[g])
        );

        fwd_mux3 #(.DATA_W(DATA_W)) u_mux (
            .sel     (sel_v[g]),
            .rf_val  (rf_v[g]),
            .exm_val (exm_result),
            .wb_val  (wb_value),
            .y       (op_v[g])
        );
    end

    assign sel_a = sel_v[0];
    assign sel_b = sel_v[1];
    assign op_a  = op_v[0];
    assign op_b  = op_v[1];

    fwd_store_byp #(.REG_W(REG_W), .DATA_W(DATA_W)) u_stb (
        .mem_wr    (mem_wr),
        .mem_rt    (mem_rt),
        .mem_sdata (mem_sdata),
        .wb_we     (wb_we),
        .wb_load   (wb_load),
        .wb_rd     (wb_rd),
        .wb_value  (wb_value),
        .byp       (st_byp),
        .wdata     (dmem_wdata)
    );
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
    parameter int REG_W  = 5,
    parameter int DATA_W = 32
) (
    input logic [REG_W-1:0]  ex_rs,
    input logic [REG_W-1:0]  ex_rt,
    input logic [DATA_W-1:0] rf_a,
    input logic [DATA_W-1:0] rf_b,
    input logic              exm_we,
    input logic [REG_W-1:0]  exm_rd,
    input logic [DATA_W-1:0] exm_result,
    input logic              wb_we,
    input logic              wb_load,
    input logic [REG_W-1:0]  wb_rd,
    input logic [DATA_W-1:0] wb_value,
    input logic              mem_wr,
    input logic [REG_W-1:0]  mem_rt,
    input logic [DATA_W-1:0] mem_sdata,
    input logic [1:0]        sel_a,
    input logic [1:0]        sel_b,
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] op_b,
    input logic              st_byp,
    input logic [DATA_W-1:0] dmem_wdata
);
    always_comb begin
        AST_SEL_LEGAL: assert (sel_a != 2'b11 && sel_b != 2'b11); // R1
        AST_OPA_ROUTE: assert (sel_a != 2'b10 || op_a == exm_result); // R1
        AST_OPB_ROUTE: assert (sel_b != 2'b01 || op_b == wb_value); // R1
        AST_EXM_SRC_A: assert (sel_a != 2'b10 || (exm_we && exm_rd != '0 && exm_rd == ex_rs)); // R2
        AST_WB_SRC_B: assert (sel_b != 2'b01 || (wb_we && wb_rd != '0 && wb_rd == ex_rt)); // R3
        AST_NEAR_WINS: assert (!(exm_we && exm_rd != '0 && exm_rd == ex_rt) || sel_b == 2'b10); // R4
        AST_ZERO_SRC: assert (ex_rs != '0 || (sel_a == 2'b00 && op_a == rf_a)); // R5
        AST_STB_DATA: assert (!st_byp || (dmem_wdata == wb_value && wb_load && mem_wr)); // R7
        AST_STB_OFF: assert (st_byp || dmem_wdata == mem_sdata); // R8
    end
endmodule

bind fwd_unit fwd_unit_chk #(.REG_W(REG_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_fwd_unit.sv
`timescale 1ns/1ps
module sim_fwd_unit;
    localparam int RW = 5;
    localparam int DW = 32;

    typedef struct {
        string     tag;
        logic [1:0] sa, sb;
        logic [DW-1:0] oa, ob, wd;
        logic      byp;
    } exp_t;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [RW-1:0] ex_rs, ex_rt, exm_rd, wb_rd, mem_rt;
    logic [DW-1:0] rf_a, rf_b, exm_result, wb_value, mem_sdata;
    logic exm_we, wb_we, wb_load, mem_wr;
    logic [1:0] sel_a, sel_b;
    logic [DW-1:0] op_a, op_b, dmem_wdata;
    logic st_byp;

    fwd_unit #(.REG_W(RW), .DATA_W(DW)) u0 (.*);

    exp_t q[$];
    int vectors = 0;
    int miscompares = 0;
    int nvec = 0;
    bit done = 1'b0;

    function automatic logic [1:0] pick(input logic [RW-1:0] s);
        if (s == 0) return 2'b00;
        if (exm_we && exm_rd == s) return 2'b10;
        if (wb_we && wb_rd == s) return 2'b01;
        return 2'b00;
    endfunction

    task automatic apply(input string tag, input logic [RW-1:0] rs, rt,
                         input logic xw, input logic [RW-1:0] xd,
                         input logic ww, wl, input logic [RW-1:0] wd,
                         input logic mw, input logic [RW-1:0] mt);
        exp_t e;
        @(negedge clk);
        nvec++;
        ex_rs = rs; ex_rt = rt; exm_we = xw; exm_rd = xd;
        wb_we = ww; wb_load = wl; wb_rd = wd; mem_wr = mw; mem_rt = mt;
        rf_a = 32'hA000_0000 + nvec; rf_b = 32'hB000_0000 + nvec;
        exm_result = 32'hE000_0000 + nvec; wb_value = 32'hC000_0000 + nvec;
        mem_sdata = 32'h5000_0000 + nvec;
        e.tag = tag;
        e.sa = pick(rs);
        e.sb = pick(rt);
        e.oa = (e.sa == 2'b10) ? exm_result : (e.sa == 2'b01) ? wb_value : rf_a;
        e.ob = (e.sb == 2'b10) ? exm_result : (e.sb == 2'b01) ? wb_value : rf_b;
        e.byp = mw && ww && wl && wd != 0 && wd == mt;
        e.wd = e.byp ? wb_value : mem_sdata;
        q.push_back(e);
    endtask

    always @(posedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            vectors++;
            if (sel_a !== e.sa || op_a !== e.oa) begin
                miscompares++;
                $display("FAIL %s operand A: sel=%b op=%h expected sel=%b op=%h", e.tag, sel_a, op_a, e.sa, e.oa);
            end
            if (sel_b !== e.sb || op_b !== e.ob) begin
                miscompares++;
                $display("FAIL %s operand B: sel=%b op=%h expected sel=%b op=%h", e.tag, sel_b, op_b, e.sb, e.ob);
            end
            if (st_byp !== e.byp || dmem_wdata !== e.wd) begin
                miscompares++;
                $display("FAIL %s store data: byp=%b wdata=%h expected byp=%b wdata=%h", e.tag, st_byp, dmem_wdata, e.byp, e.wd);
            end
        end
    end

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        // idle state, nothing enabled
        apply("R9 idle", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        apply("R1 rf path", 3, 4, 0, 3, 0, 0, 4, 0, 0);
        apply("R2 exm to A", 7, 9, 1, 7, 0, 0, 0, 0, 0);
        apply("R2 exm to both", 6, 6, 1, 6, 0, 0, 0, 0, 0);
        apply("R2 exm we low", 7, 7, 0, 7, 0, 0, 0, 0, 0);
        apply("R3 wb to B", 2, 11, 0, 0, 1, 0, 11, 0, 0);
        apply("R3 wb we low", 11, 11, 0, 0, 0, 0, 11, 0, 0);
        apply("R4 both match A", 5, 8, 1, 5, 1, 0, 5, 0, 0);
        apply("R4 both match B", 8, 31, 1, 31, 1, 1, 31, 0, 0);
        apply("R5 zero src", 0, 0, 1, 0, 1, 0, 0, 0, 0);
        apply("R5 zero dest", 0, 12, 1, 0, 1, 0, 0, 0, 0);
        apply("R6 split A exm B wb", 13, 14, 1, 13, 1, 0, 14, 0, 0);
        apply("R6 split A wb B exm", 14, 13, 1, 13, 1, 0, 14, 0, 0);
        apply("R7 load to store", 1, 2, 0, 0, 1, 1, 9, 1, 9);
        apply("R8 not a load", 1, 2, 0, 0, 1, 0, 9, 1, 9);
        apply("R8 not a store", 1, 2, 0, 0, 1, 1, 9, 0, 9);
        apply("R8 zero dest", 1, 2, 0, 0, 1, 1, 0, 1, 0);
        apply("R8 rt mismatch", 1, 2, 0, 0, 1, 1, 9, 1, 10);
        apply("R8 wb we low", 1, 2, 0, 0, 0, 1, 9, 1, 9);
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            apply("R9 random", {3'b0, lfsr[1:0]}, {3'b0, lfsr[3:2]}, lfsr[4],
                  {3'b0, lfsr[6:5]}, lfsr[7], lfsr[8], {3'b0, lfsr[10:9]},
                  lfsr[11], {3'b0, lfsr[13:12]});
        end
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule